// File: doc/BRIEF.md
# TDM Time-Slot Interchange Switch

This block moves 8-bit time slots between two serial PCM port groups: a system side and a synchronous side. Each side has four serial input lines and four serial output lines running at 2048 kbit/s. A frame holds 32 slots of 8 bits. Every bit is sent MSB first. A shared frame-sync input starts the frame on all eight inputs and all eight outputs at once. The block stores every input byte of a frame in a double buffer. During the next frame it plays out the bytes that a connection memory has selected for each output slot.

Each connection-memory entry names the source interface, the source line and the source slot for one output slot. This lets one memory describe several kinds of route. The normal route is a cross-connect between the two sides. A route may also loop back on the same side for test. An entry may also leave the output slot unconnected, so that the line idles high. Each system-side output line has a valid strobe that marks its connected slots. The block also drives a free-running bit clock at half the core clock, for devices on the synchronous side.

The core clock runs at twice the bit rate, so each bit lasts two clock cycles.

Top module: `tsi_switch`

## Requirements
- R1: While `rst_ni` is low, and after it is released with no connection written, every transmit line is high and every `sys_vld_o` bit is low; reset clears the whole connection memory.
- R2: `bclk_o` inverts on every rising edge of `clk_i` and ignores `fsync_i`.
- R3: Frame alignment works as follows. A clock edge that sees `fsync_i` high, after it was low at the previous edge, moves the block to slot 0, bit 0. Each bit lasts two clock cycles. Receive lines are sampled at the edge that ends the second cycle, and transmit lines hold the bit through both cycles. Bits go MSB first, and 256 bit positions later the count wraps to slot 0 on its own.
- R4: For a write with `cm_we_i` high, `cm_addr_i[0]` selects the output side (0 = system, 1 = synchronous), `cm_addr_i[2:1]` the output line and `cm_addr_i[7:3]` the output slot. The entry takes effect on the next clock edge.
- R5: The encoding of `cm_data_i` is as follows. Bits [1:0] give the source: 01 = system input, 10 = synchronous input, 00 or 11 = unconnected. Bits [3:2] give the source line and bits [8:4] give the source slot.
- R6: A byte that enters in frame n on one side leaves in frame n+1 on the other side, in the output slot whose entry points at it. This holds whether that slot comes earlier or later in the frame than the source slot.
- R7: An entry may route a system input to a system output, or a synchronous input to a synchronous output, with the same one-frame delay.
- R8: An output slot whose entry is unconnected drives its line high for all 8 bits.
- R9: `sys_vld_o[l]` is high for all 8 bits of each slot in which system output line l is connected, and low for all 8 bits of every other slot.
- R10: Writing an entry again replaces the old route, and writing source code 00 disconnects the slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock, twice the bit rate |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fsync_i | input | 1 | Frame sync; a rising edge starts a frame |
| sys_rx_i | input | 4 | System-side serial inputs |
| syn_rx_i | input | 4 | Synchronous-side serial inputs |
| sys_tx_o | output | 4 | System-side serial outputs |
| syn_tx_o | output | 4 | Synchronous-side serial outputs |
| sys_vld_o | output | 4 | Per-line valid strobe for system outputs |
| bclk_o | output | 1 | Free-running bit clock |
| cm_we_i | input | 1 | Connection-memory write enable |
| cm_addr_i | input | 8 | Output side, line and slot of the entry |
| cm_data_i | input | 9 | Source code, line and slot of the entry |

## Verification
The bench builds the block with its default geometry: four lines per side, 32 slots and 8-bit bytes. It therefore sees full 256-bit frames and the slot-31-to-slot-0 wrap at the frame sync. It also reaches the top line and the last slot, both as a source and as a destination. Every output slot of both sides is compared byte by byte in each checked frame. This covers routes that run backward in slot order, routes that fan out from one source, loopbacks and the reserved source code.

// File: rtl/tsi_pkg.sv
`timescale 1ns/1ps
package tsi_pkg;
  typedef enum logic [1:0] {
    SRC_NONE = 2'b00,
    SRC_SYS  = 2'b01,
    SRC_SYN  = 2'b10,
    SRC_RSV  = 2'b11
  } src_e;

  localparam int unsigned SIDE_SYS = 0;
  localparam int unsigned SIDE_SYN = 1;
  localparam int unsigned SIDES    = 2;
endpackage

// File: rtl/tsi_frame_timer.sv
`timescale 1ns/1ps
module tsi_frame_timer #(
  parameter int unsigned POS_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fsync_i,
  output logic             sof_o,
  output logic             smp_o,
  output logic             bclk_o,
  output logic [POS_W-1:0] pos_o
);
  logic             fsync_q;
  logic             ph_q;
  logic             bclk_q;
  logic [POS_W-1:0] pos_q;

  assign sof_o  = fsync_i & ~fsync_q;
  assign smp_o  = ph_q;
  assign bclk_o = bclk_q;
  assign pos_o  = pos_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fsync_q <= 1'b0;
      ph_q    <= 1'b0;
      pos_q   <= '0;
      bclk_q  <= 1'b0;
    end else begin
      fsync_q <= fsync_i;
      bclk_q  <= ~bclk_q;
      if (sof_o) begin
        ph_q  <= 1'b0;
        pos_q <= '0;
      end else begin
        ph_q <= ~ph_q;
        if (ph_q) pos_q <= pos_q + 1'b1;
      end
    end
  end

  // R2
  bclk_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (bclk_o != $past(bclk_o)));

  // R3
  sof_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_o |=> (pos_o == '0) && !smp_o);

  // R3
  bit_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sof_o && !smp_o) |=> $stable(pos_o));
endmodule

// File: rtl/tsi_capture.sv
`timescale 1ns/1ps
module tsi_capture #(
  parameter int unsigned LINES  = 4,
  parameter int unsigned SLOTS  = 32,
  parameter int unsigned BYTE_W = 8
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        sof_i,
  input  logic                        smp_i,
  input  logic [$clog2(SLOTS)-1:0]    slot_i,
  input  logic [$clog2(BYTE_W)-1:0]   bit_i,
  input  logic [LINES-1:0]            rx_i,
  output logic [BYTE_W-1:0]           rd_o [LINES][SLOTS]
);
  localparam int unsigned BIT_W = $clog2(BYTE_W);

  logic bank_q;
  logic last_bit;

  assign last_bit = (bit_i == BIT_W'(BYTE_W - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bank_q <= 1'b0;
    else if (sof_i) bank_q <= ~bank_q;
  end

  for (genvar l = 0; l < LINES; l++) begin : g_line
    logic [BYTE_W-2:0] sh_q;
    logic [BYTE_W-1:0] buf_q [2][SLOTS];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sh_q <= '0;
        for (int b = 0; b < 2; b++)
          for (int s = 0; s < SLOTS; s++)
            buf_q[b][s] <= '1;
      end else if (smp_i) begin
        sh_q <= {sh_q[BYTE_W-3:0], rx_i[l]};
        if (last_bit) buf_q[bank_q][slot_i] <= {sh_q, rx_i[l]};
      end
    end

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      assign rd_o[l][s] = buf_q[~bank_q][s];
    end
  end

  // R6
  bank_swap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_i |=> (bank_q != $past(bank_q)));

  // R6
  bank_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sof_i |=> $stable(bank_q));
endmodule

// File: rtl/tsi_conn_mem.sv
`timescale 1ns/1ps
module tsi_conn_mem
  import tsi_pkg::*;
#(
  parameter int unsigned LINES = 4,
  parameter int unsigned SLOTS = 32,
  localparam int unsigned LINE_W = $clog2(LINES),
  localparam int unsigned SLOT_W = $clog2(SLOTS),
  localparam int unsigned ADDR_W = 1 + LINE_W + SLOT_W,
  localparam int unsigned DATA_W = 2 + LINE_W + SLOT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [SLOT_W-1:0] slot_i,
  output logic [DATA_W-1:0] ent_o [SIDES][LINES]
);
  localparam int unsigned ENTRIES = SIDES * LINES * SLOTS;

  logic [DATA_W-1:0] mem_q [ENTRIES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ENTRIES; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[addr_i] <= data_i;
    end
  end

  // entry index is {slot, line, side}
  for (genvar sd = 0; sd < SIDES; sd++) begin : g_side
    for (genvar l = 0; l < LINES; l++) begin : g_line
      assign ent_o[sd][l] = mem_q[{slot_i, LINE_W'(l), 1'(sd)}];
    end
  end

  // R4
  cm_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (mem_q[$past(addr_i)] == $past(data_i)));
endmodule

// File: rtl/tsi_switch.sv
`timescale 1ns/1ps
module tsi_switch
  import tsi_pkg::*;
#(
  parameter int unsigned LINES  = 4,
  parameter int unsigned SLOTS  = 32,
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned LINE_W = $clog2(LINES),
  localparam int unsigned SLOT_W = $clog2(SLOTS),
  localparam int unsigned BIT_W  = $clog2(BYTE_W),
  localparam int unsigned POS_W  = SLOT_W + BIT_W,
  localparam int unsigned ADDR_W = 1 + LINE_W + SLOT_W,
  localparam int unsigned DATA_W = 2 + LINE_W + SLOT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fsync_i,
  input  logic [LINES-1:0]  sys_rx_i,
  input  logic [LINES-1:0]  syn_rx_i,
  output logic [LINES-1:0]  sys_tx_o,
  output logic [LINES-1:0]  syn_tx_o,
  output logic [LINES-1:0]  sys_vld_o,
  output logic              bclk_o,
  input  logic              cm_we_i,
  input  logic [ADDR_W-1:0] cm_addr_i,
  input  logic [DATA_W-1:0] cm_data_i
);
  logic              sof;
  logic              smp;
  logic [POS_W-1:0]  pos;
  logic [SLOT_W-1:0] slot;
  logic [BIT_W-1:0]  bit_idx;

  logic [BYTE_W-1:0] sys_rd [LINES][SLOTS];
  logic [BYTE_W-1:0] syn_rd [LINES][SLOTS];
  logic [DATA_W-1:0] ent_w  [SIDES][LINES];

  assign slot    = pos[POS_W-1:BIT_W];
  assign bit_idx = pos[BIT_W-1:0];

  tsi_frame_timer #(.POS_W(POS_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fsync_i(fsync_i),
    .sof_o  (sof),
    .smp_o  (smp),
    .bclk_o (bclk_o),
    .pos_o  (pos)
  );

  tsi_capture #(.LINES(LINES), .SLOTS(SLOTS), .BYTE_W(BYTE_W)) u_cap_sys (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sof_i (sof),
    .smp_i (smp),
    .slot_i(slot),
    .bit_i (bit_idx),
    .rx_i  (sys_rx_i),
    .rd_o  (sys_rd)
  );

  tsi_capture #(.LINES(LINES), .SLOTS(SLOTS), .BYTE_W(BYTE_W)) u_cap_syn (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sof_i (sof),
    .smp_i (smp),
    .slot_i(slot),
    .bit_i (bit_idx),
    .rx_i  (syn_rx_i),
    .rd_o  (syn_rd)
  );

  tsi_conn_mem #(.LINES(LINES), .SLOTS(SLOTS)) u_cm (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_i  (cm_we_i),
    .addr_i(cm_addr_i),
    .data_i(cm_data_i),
    .slot_i(slot),
    .ent_o (ent_w)
  );

  for (genvar sd = 0; sd < SIDES; sd++) begin : g_side
    for (genvar l = 0; l < LINES; l++) begin : g_line
      logic [DATA_W-1:0] ent;
      src_e              typ;
      logic [LINE_W-1:0] src_line;
      logic [SLOT_W-1:0] src_slot;
      logic [BYTE_W-1:0] byt;
      logic              conn;
      logic              tx;

      always_comb begin
        ent      = ent_w[sd][l];
        typ      = src_e'(ent[1:0]);
        src_line = ent[LINE_W+1:2];
        src_slot = ent[DATA_W-1:LINE_W+2];
        conn     = (typ == SRC_SYS) || (typ == SRC_SYN);
        byt      = (typ == SRC_SYN) ? syn_rd[src_line][src_slot]
                                    : sys_rd[src_line][src_slot];
        tx       = conn ? byt[BIT_W'(BYTE_W - 1) - bit_idx] : 1'b1;
      end

      if (sd == SIDE_SYS) begin : g_sys
        assign sys_tx_o[l]  = tx;
        assign sys_vld_o[l] = conn;

        // R8
        idle_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
          !sys_vld_o[l] |-> sys_tx_o[l]);
      end else begin : g_syn
        assign syn_tx_o[l] = tx;
      end
    end
  end

  // R9
  vld_slot_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cm_we_i && !sof && !(smp && bit_idx == BIT_W'(BYTE_W - 1))) |=> $stable(sys_vld_o));
endmodule

// File: tb/tb_tsi_switch.sv
`timescale 1ns/1ps
module tb_tsi_switch;
  localparam int LINES = 4;
  localparam int SLOTS = 32;
  localparam int NPOS  = SLOTS * 8;
  localparam int NVEC  = 11;

  // {out_side, out_line[1:0], out_slot[4:0], src_code[1:0], src_line[1:0], src_slot[4:0]}
  localparam logic [16:0] CM_VEC [NVEC] = '{
    {1'b0, 2'd0, 5'd0,  2'b10, 2'd0, 5'd0 },
    {1'b0, 2'd1, 5'd5,  2'b10, 2'd3, 5'd31},
    {1'b0, 2'd3, 5'd31, 2'b10, 2'd2, 5'd0 },
    {1'b1, 2'd0, 5'd0,  2'b01, 2'd1, 5'd7 },
    {1'b1, 2'd2, 5'd10, 2'b01, 2'd3, 5'd31},
    {1'b1, 2'd3, 5'd31, 2'b01, 2'd0, 5'd0 },
    {1'b0, 2'd2, 5'd12, 2'b01, 2'd2, 5'd13},
    {1'b1, 2'd1, 5'd3,  2'b10, 2'd1, 5'd3 },
    {1'b0, 2'd0, 5'd1,  2'b10, 2'd0, 5'd0 },
    {1'b1, 2'd0, 5'd20, 2'b10, 2'd3, 5'd31},
    {1'b0, 2'd1, 5'd6,  2'b11, 2'd2, 5'd2 }
  };

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             fsync_i = 1'b0;
  logic [LINES-1:0] sys_rx_i = '1;
  logic [LINES-1:0] syn_rx_i = '1;
  logic [LINES-1:0] sys_tx_o;
  logic [LINES-1:0] syn_tx_o;
  logic [LINES-1:0] sys_vld_o;
  logic             bclk_o;
  logic             cm_we_i = 1'b0;
  logic [7:0]       cm_addr_i = '0;
  logic [8:0]       cm_data_i = '0;

  tsi_switch dut (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .fsync_i  (fsync_i),
    .sys_rx_i (sys_rx_i),
    .syn_rx_i (syn_rx_i),
    .sys_tx_o (sys_tx_o),
    .syn_tx_o (syn_tx_o),
    .sys_vld_o(sys_vld_o),
    .bclk_o   (bclk_o),
    .cm_we_i  (cm_we_i),
    .cm_addr_i(cm_addr_i),
    .cm_data_i(cm_data_i)
  );

  always #10 clk_i = ~clk_i;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  int         m_code [2][LINES][SLOTS];
  int         m_line [2][LINES][SLOTS];
  int         m_slot [2][LINES][SLOTS];
  logic [7:0] got    [2][LINES][SLOTS];
  logic [7:0] vbits  [LINES][SLOTS];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int side, input int line, input int slot, input int fr);
    int v;
    v = ((side << 7) | (line << 5) | slot) + fr * 37;
    return v[7:0];
  endfunction

  task automatic cm_write(input int sd, input int ln, input int sl, input int code,
                          input int src_l, input int src_s);
    @(negedge clk_i);
    cm_we_i   = 1'b1;
    cm_addr_i = {sl[4:0], ln[1:0], sd[0]};
    cm_data_i = {src_s[4:0], src_l[1:0], code[1:0]};
    @(negedge clk_i);
    cm_we_i = 1'b0;
    m_code[sd][ln][sl] = code;
    m_line[sd][ln][sl] = src_l;
    m_slot[sd][ln][sl] = src_s;
  endtask

  task automatic start_seq();
    @(negedge clk_i);
    fsync_i = 1'b0;
    @(negedge clk_i);
    fsync_i = 1'b1;
  endtask

  task automatic check_idle(input string req);
    chk(sys_tx_o == '1, req, sys_tx_o, 4'hF);
    chk(syn_tx_o == '1, req, syn_tx_o, 4'hF);
    chk(sys_vld_o == '0, req, sys_vld_o, 0);
  endtask

  // drives frame fr, captures outputs, checks against data of frame fr-1
  task automatic run_frame(input int fr, input bit do_check);
    for (int k = 0; k < NPOS; k++) begin
      int s;
      int b;
      s = k / 8;
      b = k % 8;
      @(negedge clk_i);
      fsync_i = 1'b0;
      for (int l = 0; l < LINES; l++) begin
        logic [7:0] bs;
        logic [7:0] bn;
        bs = pat(0, l, s, fr);
        bn = pat(1, l, s, fr);
        sys_rx_i[l] = bs[7-b];
        syn_rx_i[l] = bn[7-b];
      end
      #1;
      for (int l = 0; l < LINES; l++) begin
        got[0][l][s][7-b] = sys_tx_o[l];
        got[1][l][s][7-b] = syn_tx_o[l];
        vbits[l][s][7-b]  = sys_vld_o[l];
      end
      @(negedge clk_i);
      if (k == NPOS - 1) fsync_i = 1'b1;
    end
    if (do_check) begin
      for (int sd = 0; sd < 2; sd++) begin
        for (int l = 0; l < LINES; l++) begin
          for (int s = 0; s < SLOTS; s++) begin
            int c;
            logic [7:0] exp;
            bit conn;
            c    = m_code[sd][l][s];
            conn = (c == 1) || (c == 2);
            exp  = conn ? pat(c - 1, m_line[sd][l][s], m_slot[sd][l][s], fr - 1) : 8'hFF;
            if (!conn)
              chk(got[sd][l][s] == exp, "R8 R5 R10", got[sd][l][s], exp);
            else if (c - 1 == sd)
              chk(got[sd][l][s] == exp, "R7 R3 R4 R5", got[sd][l][s], exp);
            else
              chk(got[sd][l][s] == exp, "R6 R3 R4 R5", got[sd][l][s], exp);
            if (sd == 0)
              chk(vbits[l][s] == (conn ? 8'hFF : 8'h00), "R9", vbits[l][s], conn ? 8'hFF : 8'h00);
          end
        end
      end
    end
  endtask

  initial begin
    for (int sd = 0; sd < 2; sd++)
      for (int l = 0; l < LINES; l++)
        for (int s = 0; s < SLOTS; s++) begin
          m_code[sd][l][s] = 0;
          m_line[sd][l][s] = 0;
          m_slot[sd][l][s] = 0;
        end

    // R1: reset state
    #35;
    check_idle("R1");
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_idle("R1");

    // R2: free-running bit clock, unaffected by frame sync
    begin
      logic prev;
      prev = bclk_o;
      for (int i = 0; i < 16; i++) begin
        @(negedge clk_i);
        fsync_i = (i == 5);
        chk(bclk_o != prev, "R2", bclk_o, !prev);
        prev = bclk_o;
      end
      fsync_i = 1'b0;
    end

    // connection table walked by one loop (R4 R5)
    for (int i = 0; i < NVEC; i++) begin
      logic [16:0] v;
      v = CM_VEC[i];
      cm_write(v[16], v[15:14], v[13:9], v[8:7], v[6:5], v[4:0]);
    end

    start_seq();
    run_frame(0, 1'b0);
    run_frame(1, 1'b1);
    run_frame(2, 1'b1);
    run_frame(3, 1'b1);

    // R10: disconnect one slot and re-route another
    cm_write(0, 0, 0, 0, 0, 0);
    cm_write(1, 0, 0, 1, 2, 9);
    cm_write(0, 3, 31, 0, 1, 1);
    start_seq();
    run_frame(10, 1'b0);
    run_frame(11, 1'b1);

    // R1: reset while connections are loaded clears them
    @(negedge clk_i);
    fsync_i = 1'b0;
    rst_ni  = 1'b0;
    #1;
    check_idle("R1");
    @(negedge clk_i);
    rst_ni = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk_i);
      check_idle("R1");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule